// File: doc/BRIEF.md
# Register Write-Readback Test Engine

This block is a hardware self-test engine for a small bank of read/write registers or RAM words. It drives a single-cycle memory port: a write strobe with address and data, and a read strobe whose data comes back on the next cycle. A one-cycle start pulse, together with a mode and an inclusive address window, launches a run. The engine walks the window from its low address upward. At each address it applies a sequence of data values selected by the mode, and checks every value by reading it straight back.

Four modes are available. Two fixed complementary patterns are written and read back. A counting sequence walks through every nonzero value. A shrinking fill clears one bit per step from the top down. A read-only mode sums the window and expects the total to be zero. The result is held on the outputs until the next start: done, a fail flag, the failing address, the expected value and the observed value. The first mismatch halts the run at once.

Top module: `regtest_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, fail, the write strobe and the read strobe are all low.
- R2: A start pulse seen while busy is low launches a run: busy is high from the next cycle, and done and fail are low. A start pulse seen while busy is high has no effect on the run, its bus traffic or its result, including when it arrives in the run's final compare cycle.
- R3: Every write is followed in the next cycle by exactly one read of the same address. The read data is compared one cycle after the read strobe, and the next write follows that compare cycle. Write and read strobes are never high together, and neither is high while busy is low.
- R4: Mode code 2'b00 is fixed-pattern mode: each address gets a write and read of 8'h55 (alternating bits, LSB set), then a write and read of 8'hAA. Addresses run from the low address up to the high address inclusive, finishing every pattern on one address before moving to the next, and wrapping modulo 2^AW when the high address is below the low one.
- R5: Mode code 2'b01 is the rolling-ones mode: each address receives every value from 1 up to all-ones in increasing order, each written and read back.
- R6: Mode code 2'b10 is the rolling-zeros mode: each address receives all-ones with the top bit cleared, then the value shifted right by one per step, ending at zero. A stuck-at-0 top bit is therefore never detected in this mode.
- R7: Mode code 2'b11 is checksum mode: it issues only reads, one per address, and adds the read data modulo 2^DW. The run passes only when the final sum is zero. On failure it reports the high address, an expected value of 0 and the sum as the observed value.
- R8: A readback that differs from the value just written ends the run in that compare cycle: no further bus traffic, done and fail go high, and the failing address, written value and read value are latched.
- R9: After a run ends, busy is low and done, fail and the three failure fields hold their values until the next accepted start. On a passing run the failure fields read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch request |
| mode | input | 2 | Test selection: 00 fixed, 01 rolling ones, 10 rolling zeros, 11 checksum |
| addr_lo | input | AW | First address of the window |
| addr_hi | input | AW | Last address of the window, inclusive |
| mem_we | output | 1 | Write strobe to the memory port |
| mem_re | output | 1 | Read strobe to the memory port |
| mem_addr | output | AW | Address for the current strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| fail | output | 1 | Run finished with an error |
| fail_addr | output | AW | Address where the error was found |
| fail_exp | output | DW | Value that was expected |
| fail_act | output | DW | Value that was observed |

## Verification
A start request can land in the same cycle as the final compare. In that cycle the engine is still busy, but it is about to raise done and release the port. The bench pulses start in exactly that cycle of a wrapped rolling-ones run. It then checks that done rises with the original verdict and that no new bus traffic appears during the following idle cycles. A second collision, a mismatch found on the last address, is provoked with an injected stuck bit. It is judged by the latched failure fields and by an empty expected-traffic queue.

// File: rtl/regtest_pkg.sv
package regtest_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED = 2'b00,
        MODE_ONES  = 2'b01,
        MODE_ZEROS = 2'b10,
        MODE_CSUM  = 2'b11
    } rt_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CHECK,
        ST_HALT
    } rt_state_e;

    function automatic logic mode_reads_only(rt_mode_e m);
        return m == MODE_CSUM;
    endfunction

endpackage

// File: rtl/rt_pattern_gen.sv
module rt_pattern_gen import regtest_pkg::*; #(
    parameter int DW = 8
) (
    input  rt_mode_e        mode,
    input  logic [DW-1:0]   cur,
    output logic [DW-1:0]   first,
    output logic [DW-1:0]   next,
    output logic            last
);
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
    localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] alt_a;

    always_comb begin
        for (int i = 0; i < DW; i++) alt_a[i] = (i % 2 == 0);
    end

    always_comb begin
        unique case (mode)
            MODE_FIXED: begin
                first = alt_a;
                next  = ~alt_a;
                last  = (cur == ~alt_a);
            end
            MODE_ONES: begin
                first = ONE;
                next  = cur + ONE;
                last  = (cur == ALL_ONES);
            end
            MODE_ZEROS: begin
                first = ALL_ONES >> 1;
                next  = cur >> 1;
                last  = (cur == '0);
            end
            default: begin
                first = '0;
                next  = cur;
                last  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rt_addr_counter.sv
module rt_addr_counter #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= lo;
        else if (step) addr <= addr + 1'b1;
    end

    assign at_end = (addr == hi);
endmodule

// File: rtl/rt_sum_acc.sv
module rt_sum_acc #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          add,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sum_next
);
    logic [DW-1:0] sum_q;

    assign sum_next = sum_q + din;

    always_ff @(posedge clk) begin
        if (rst || clear) sum_q <= '0;
        else if (add)     sum_q <= sum_next;
    end
endmodule

// File: rtl/regtest_engine.sv
module regtest_engine import regtest_pkg::*; #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr_lo,
    input  logic [AW-1:0] addr_hi,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_act
);
    rt_state_e     state;
    rt_mode_e      run_mode, sel_mode;
    logic [AW-1:0] hi_q, addr;
    logic [DW-1:0] pat, pat_first, pat_next, sum_nx;
    logic          pat_last, at_end, launch, csum_run, in_check, cmp_bad, step_addr;

    assign busy      = (state == ST_WRITE) || (state == ST_READ) || (state == ST_CHECK);
    assign launch    = start && !busy;
    assign sel_mode  = launch ? rt_mode_e'(mode) : run_mode;
    assign csum_run  = mode_reads_only(run_mode);
    assign in_check  = (state == ST_CHECK);
    assign cmp_bad   = (mem_rdata != pat);
    assign step_addr = in_check && !at_end && (csum_run || (!cmp_bad && pat_last));

    assign mem_we    = (state == ST_WRITE);
    assign mem_re    = (state == ST_READ);
    assign mem_addr  = addr;
    assign mem_wdata = pat;

    rt_pattern_gen #(.DW(DW)) u_pat (
        .mode (sel_mode),
        .cur  (pat),
        .first(pat_first),
        .next (pat_next),
        .last (pat_last)
    );

    rt_addr_counter #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .load  (launch),
        .step  (step_addr),
        .lo    (addr_lo),
        .hi    (hi_q),
        .addr  (addr),
        .at_end(at_end)
    );

    rt_sum_acc #(.DW(DW)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .clear   (launch),
        .add     (in_check && csum_run),
        .din     (mem_rdata),
        .sum_next(sum_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            run_mode  <= MODE_FIXED;
            hi_q      <= '0;
            pat       <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (launch) begin
            run_mode  <= sel_mode;
            hi_q      <= addr_hi;
            pat       <= pat_first;
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
            state     <= mode_reads_only(sel_mode) ? ST_READ : ST_WRITE;
        end else begin
            unique case (state)
                ST_WRITE: state <= ST_READ;
                ST_READ:  state <= ST_CHECK;
                ST_CHECK: begin
                    if (csum_run) begin
                        if (at_end) begin
                            state <= ST_HALT;
                            done  <= 1'b1;
                            if (sum_nx != '0) begin
                                fail      <= 1'b1;
                                fail_addr <= addr;
                                fail_exp  <= '0;
                                fail_act  <= sum_nx;
                            end
                        end else begin
                            state <= ST_READ;
                        end
                    end else if (cmp_bad) begin
                        state     <= ST_HALT;
                        done      <= 1'b1;
                        fail      <= 1'b1;
                        fail_addr <= addr;
                        fail_exp  <= pat;
                        fail_act  <= mem_rdata;
                    end else if (!pat_last) begin
                        pat   <= pat_next;
                        state <= ST_WRITE;
                    end else if (at_end) begin
                        state <= ST_HALT;
                        done  <= 1'b1;
                    end else begin
                        pat   <= pat_first;
                        state <= ST_WRITE;
                    end
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/rt_engine_chk.sv
module rt_engine_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          csum_run
);
    // R1: quiet state after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !done && !fail && !mem_we && !mem_re));

    // R3: read of the same address follows each write
    a_r3_read_after_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_re && mem_addr == $past(mem_addr)));

    // R3: strobes exclusive
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R3: traffic only during a run
    a_r3_traffic_when_busy: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    // R7: checksum never writes
    a_r7_csum_read_only: assert property (@(posedge clk) disable iff (rst)
        (busy && csum_run) |-> !mem_we);

    // R8: fail comes with done and the run stopped
    a_r8_fail_halts: assert property (@(posedge clk) disable iff (rst)
        fail |-> (done && !busy));

    // R9: verdict holds until a new start
    a_r9_verdict_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail)));
endmodule

bind regtest_engine rt_engine_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .fail    (fail),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .mem_addr(mem_addr),
    .csum_run(csum_run)
);

// File: tb/regtest_engine_tb_top.sv
module regtest_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int NADDR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] addr_lo = '0, addr_hi = '0;
    logic          mem_we, mem_re, busy, done, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata, fail_exp, fail_act;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem_m [NADDR];
    logic          f_en = 1'b0;
    logic [AW-1:0] f_addr = '0;
    logic [DW-1:0] f_mask = '0;

    int q_we[$];
    int q_addr[$];
    int q_data[$];
    bit            e_fail;
    int            e_faddr, e_fexp, e_fact;

    always #(CLK_PERIOD/2) clk = ~clk;

    regtest_engine #(.DW(DW), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .addr_lo(addr_lo), .addr_hi(addr_hi),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    // memory model: write stores data minus stuck-at-0 bits, read data next cycle
    function automatic logic [DW-1:0] stuck(int a);
        return (f_en && a == int'(f_addr)) ? f_mask : '0;
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem_m[mem_addr] <= mem_wdata & ~stuck(int'(mem_addr));
        if (mem_re) mem_rdata <= mem_m[mem_addr];
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference sequence of bus operations and verdict
    task automatic build(int m, int lo, int hi);
        int pats[$];
        int a;
        int sum;
        q_we.delete(); q_addr.delete(); q_data.delete();
        e_fail = 0; e_faddr = 0; e_fexp = 0; e_fact = 0;
        if (m == 0) begin pats.push_back(8'h55); pats.push_back(8'hAA); end
        if (m == 1) for (int v = 1; v < 256; v++) pats.push_back(v);
        if (m == 2) for (int k = 1; k <= 8; k++) pats.push_back(8'hFF >> k);
        a = lo; sum = 0;
        forever begin
            if (m == 3) begin
                q_we.push_back(0); q_addr.push_back(a); q_data.push_back(0);
                sum = (sum + int'(mem_m[a])) % 256;
            end else begin
                foreach (pats[i]) begin
                    int rb;
                    q_we.push_back(1); q_addr.push_back(a); q_data.push_back(pats[i]);
                    q_we.push_back(0); q_addr.push_back(a); q_data.push_back(0);
                    rb = pats[i] & ~int'(stuck(a));
                    if (rb != pats[i]) begin
                        e_fail = 1; e_faddr = a; e_fexp = pats[i]; e_fact = rb;
                        return;
                    end
                end
            end
            if (a == hi) break;
            a = (a + 1) % NADDR;
        end
        if (m == 3 && sum != 0) begin
            e_fail = 1; e_faddr = hi; e_fexp = 0; e_fact = sum;
        end
    endtask

    task automatic run(int m, int lo, int hi, string tag, bit poke_mid, bit poke_end);
        int cyc;
        bit armed;
        build(m, lo, hi);
        mode = 2'(m); addr_lo = AW'(lo); addr_hi = AW'(hi);
        start = 1'b1;
        cyc = 0; armed = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc == 1)
                chk(busy && !done && !fail, "R2", "launch state busy/done/fail",
                    {busy, done, fail}, 3'b100);
            if (armed) begin
                start = 1'b1; mode = 2'(m ^ 1); armed = 0;  // R2 start in final compare cycle
            end
            if (poke_mid && cyc == 6) begin
                start = 1'b1; mode = 2'(m ^ 2); addr_lo = AW'(lo + 3);  // R2 ignored while busy
            end
            if (mem_we || mem_re) begin
                if (q_we.size() == 0) begin
                    chk(0, "R3", "unexpected bus op at addr", int'(mem_addr), -1);
                end else begin
                    int ew, ea, ed;
                    ew = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front();
                    chk(int'(mem_we) == ew && int'(mem_re) == 1 - ew, "R3", "op kind we",
                        int'(mem_we), ew);
                    chk(int'(mem_addr) == ea, "R4", "op address", int'(mem_addr), ea);
                    if (ew == 1) chk(int'(mem_wdata) == ed, tag, "write data",
                                     int'(mem_wdata), ed);
                    if (q_we.size() == 0 && poke_end) armed = 1;
                end
            end
            if (done) break;
            chk(busy, "R2", "busy during run", int'(busy), 1);
            if (cyc > 20000) begin
                chk(0, tag, "run did not finish", cyc, 0);
                break;
            end
        end
        start = 1'b0;
        chk(q_we.size() == 0, "R8", "ops left unissued", q_we.size(), 0);
        chk(int'(fail) == int'(e_fail), tag, "verdict fail", int'(fail), int'(e_fail));
        chk(int'(fail_addr) == e_faddr, "R8", "fail_addr", int'(fail_addr), e_faddr);
        chk(int'(fail_exp) == e_fexp, "R8", "fail_exp", int'(fail_exp), e_fexp);
        chk(int'(fail_act) == e_fact, "R8", "fail_act", int'(fail_act), e_fact);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!busy && done && !mem_we && !mem_re, "R9", "idle hold busy/done/we/re",
                {busy, done, mem_we, mem_re}, 4'b0100);
            chk(int'(fail) == int'(e_fail), "R9", "fail held", int'(fail), int'(e_fail));
        end
    endtask

    initial begin
        for (int i = 0; i < NADDR; i++) mem_m[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R1", "outputs in reset",
            {busy, done, fail, mem_we, mem_re}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R1", "outputs after reset",
            {busy, done, fail, mem_we, mem_re}, 0);

        run(0, 2, 5, "R4", 1'b1, 1'b0);                  // fixed, clean, start mid-run
        f_en = 1'b1; f_addr = 4'd3; f_mask = 8'h04;
        run(0, 2, 5, "R8", 1'b0, 1'b0);                  // fixed, stuck bit 2 at addr 3
        f_en = 1'b0;
        run(1, 14, 1, "R5", 1'b0, 1'b1);                 // ones, wrapped window, late start
        f_en = 1'b1; f_addr = 4'd1; f_mask = 8'h80;
        run(2, 0, 3, "R6", 1'b0, 1'b0);                  // zeros, top-bit stuck invisible
        f_addr = 4'd3; f_mask = 8'h01;
        run(1, 2, 3, "R8", 1'b0, 1'b0);                  // ones, fault on last address
        f_en = 1'b0;
        mem_m[8] = 8'd10; mem_m[9] = 8'd20; mem_m[10] = 8'd30; mem_m[11] = 8'd196;
        run(3, 8, 11, "R7", 1'b0, 1'b0);                 // checksum zero
        mem_m[11] = 8'd200;
        run(3, 8, 11, "R7", 1'b0, 1'b0);                 // checksum nonzero
        run(3, 9, 9, "R7", 1'b0, 1'b0);                  // single-word checksum

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule